// File: doc/BRIEF.md
# Windowed Register File with Circular Overlapping Windows

This block is a register file for a processor that gives each procedure its own set of registers. A 5-bit register number selects one of 32 visible registers. The 8 lowest numbers are global and reach the same storage from every window. The other 24 come from the current window, which is one of `NUM_WIN` windows held in a physical array of `NUM_WIN`×16 entries. The block has two combinational read ports and one write port. A write lands on the clock edge, and a read in the same cycle already sees the value being written.

A window pointer chooses the current window. A call command moves it down by one and a return command moves it up by one, both modulo `NUM_WIN`. Neighbouring windows share one group of 8 registers, so a caller passes values to its callee without copying. The windows form a ring, so the last window shares a group with the first. An invalid-window mask names a window that must not be entered. A call or return that would enter it leaves the pointer where it is and raises an overflow or underflow pulse, which a spill or fill handler elsewhere can act on. `NUM_WIN` must be a power of two.

Register grouping, by visible number:
- 1..7: global, and 0 is hard-wired to zero.
- 8..15: shared with the next lower window.
- 16..23: private to the window.
- 24..31: shared with the next higher window.

Top module: `win_regfile`

## Requirements
- R1: Register 0 reads as zero on both read ports, including in the cycle it is written. A write to it changes nothing that can be read.
- R2: Registers 1..7 are global. A value written to one of them in any window reads back the same from every window.
- R3: Registers 16..23 of a window are private. A write to them is seen only from that window.
- R4: Registers 24..31 of window w are the same storage as registers 8..15 of window (w+1) mod NUM_WIN, in the same order. This includes the wrap from the last window to window 0.
- R5: A call alone moves `cwp_o` to (cwp−1) mod NUM_WIN, and a return alone moves it to (cwp+1) mod NUM_WIN. The new value shows in the cycle after the command. With both commands or neither, the pointer holds.
- R6: A call whose target window has its bit set in `inv_mask_i` (bit k marks window k) leaves the pointer unchanged. `ovf_o` is then high for exactly the one cycle after the command, and `unf_o` stays low.
- R7: A return whose target window is marked leaves the pointer unchanged. `unf_o` is then high for exactly the one cycle after the command, and `ovf_o` stays low.
- R8: A read of the register being written in the same cycle returns the write data on both ports. Reads of other registers are not affected by that write.
- R9: After reset, `cwp_o` is 0, both flags are low, and every register reads zero.
- R10: A write uses the window that is current in the cycle it is issued, even when a call or return is issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call command, moves the window down |
| ret_i | input | 1 | Return command, moves the window up |
| inv_mask_i | input | NUM_WIN | Invalid-window mask, bit k marks window k |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write register number |
| wdata_i | input | DATA_W | Write data |
| raddr_a_i | input | 5 | Read port A register number |
| raddr_b_i | input | 5 | Read port B register number |
| rdata_a_o | output | DATA_W | Read port A data |
| rdata_b_o | output | DATA_W | Read port B data |
| cwp_o | output | CWP_W | Current window pointer |
| ovf_o | output | 1 | Window overflow pulse |
| unf_o | output | 1 | Window underflow pulse |

## Verification
The pointer-step properties assume that a call or return is judged against the mask value present in the same cycle. The mask is taken to be stable around each command. The stimulus changes the mask only in idle cycles, and it keeps the mask at zero during the window sweeps, so that no intended move is refused. The bypass property compares only register numbers within one cycle, which holds because the pointer changes only at the edge. The bench therefore issues every write and read against a settled pointer.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int ARCH_W  = 5;
  localparam int GRP_SZ  = 8;
  localparam int WIN_SZ  = 2 * GRP_SZ;
  localparam int WIN_SH  = $clog2(WIN_SZ);
  localparam int NUM_GRP = (1 << ARCH_W) / GRP_SZ;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_CALL = 2'b01,
    CMD_RET  = 2'b10,
    CMD_BOTH = 2'b11
  } win_cmd_e;
endpackage

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int CWP_W  = $clog2(NUM_WIN),
  localparam int WIDX_W = CWP_W + WIN_SH,
  localparam int PIDX_W = $clog2(NUM_WIN * WIN_SZ + GRP_SZ)
) (
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [ARCH_W-1:0] arch_i,
  output logic [PIDX_W-1:0] phys_o,
  output logic              zero_o
);
  logic              is_glb;
  logic [ARCH_W-1:0] win_off;
  logic [WIDX_W-1:0] wsum;

  assign is_glb  = arch_i < ARCH_W'(GRP_SZ);
  assign win_off = arch_i - ARCH_W'(GRP_SZ);
  // power-of-two ring: wrap comes from truncation
  assign wsum    = {cwp_i, {WIN_SH{1'b0}}} + WIDX_W'(win_off);
  assign phys_o  = is_glb ? PIDX_W'(arch_i) : PIDX_W'(GRP_SZ) + PIDX_W'(wsum);
  assign zero_o  = (arch_i == '0);
endmodule

// File: rtl/wrf_cwp_ctrl.sv
module wrf_cwp_ctrl
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int CWP_W  = $clog2(NUM_WIN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic [NUM_WIN-1:0] inv_mask_i,
  output logic [CWP_W-1:0]   cwp_o,
  output logic               ovf_o,
  output logic               unf_o
);
  win_cmd_e         cmd;
  logic [CWP_W-1:0] cwp_q, cwp_d, cwp_dn, cwp_up;
  logic             ovf_q, unf_q, ovf_d, unf_d;

  assign cmd    = win_cmd_e'({ret_i, call_i});
  assign cwp_dn = cwp_q - 1'b1;
  assign cwp_up = cwp_q + 1'b1;

  always_comb begin
    cwp_d = cwp_q;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    unique case (cmd)
      CMD_CALL: begin
        ovf_d = inv_mask_i[cwp_dn];
        if (!ovf_d) cwp_d = cwp_dn;
      end
      CMD_RET: begin
        unf_d = inv_mask_i[cwp_up];
        if (!unf_d) cwp_d = cwp_up;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cwp_q <= cwp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_call_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !inv_mask_i[cwp_q - 1'b1]) |=> (cwp_q == CWP_W'($past(cwp_q) - 1'b1)))
    else $error("call step");
  p_ret_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !inv_mask_i[cwp_q + 1'b1]) |=> (cwp_q == CWP_W'($past(cwp_q) + 1'b1)))
    else $error("return step");
  p_both_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i == ret_i) |=> $stable(cwp_q))
    else $error("pointer moved without single command");
  p_no_overflow_move_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cwp_q == $past(cwp_q)))
    else $error("pointer moved on overflow");
  p_no_underflow_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> (cwp_q == $past(cwp_q)))
    else $error("pointer moved on underflow");
  p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_q, unf_q}))
    else $error("both flags high");
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int NRD     = 2,
  localparam int PHYS   = NUM_WIN * WIN_SZ + GRP_SZ,
  localparam int PIDX_W = $clog2(PHYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [PIDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [NRD-1:0][PIDX_W-1:0]  rd_idx_i,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data_o
);
  logic [DATA_W-1:0] mem_q [PHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_idx_i[p]];
  end

  p_no_zero_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i != '0))
    else $error("write reached hard-wired zero");
endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port
  import wrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PIDX_W = 8
) (
  input  logic              zero_i,
  input  logic [PIDX_W-1:0] rd_idx_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              wr_en_i,
  input  logic [PIDX_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic hit;

  assign hit = wr_en_i && (wr_idx_i == rd_idx_i);

  always_comb begin
    if (zero_i)   rd_data_o = '0;
    else if (hit) rd_data_o = wr_data_i;
    else          rd_data_o = mem_data_i;
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  localparam int CWP_W  = $clog2(NUM_WIN),
  localparam int PIDX_W = $clog2(NUM_WIN * WIN_SZ + GRP_SZ),
  localparam int NRD    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic [NUM_WIN-1:0] inv_mask_i,
  input  logic               we_i,
  input  logic [ARCH_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [ARCH_W-1:0]  raddr_a_i,
  input  logic [ARCH_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0]  rdata_a_o,
  output logic [DATA_W-1:0]  rdata_b_o,
  output logic [CWP_W-1:0]   cwp_o,
  output logic               ovf_o,
  output logic               unf_o
);
  logic [CWP_W-1:0]             cwp;
  logic [NRD-1:0][ARCH_W-1:0]   rd_arch;
  logic [NRD-1:0][PIDX_W-1:0]   rd_idx;
  logic [NRD-1:0]               rd_zero;
  logic [NRD-1:0][DATA_W-1:0]   mem_data;
  logic [NRD-1:0][DATA_W-1:0]   rd_data;
  logic [PIDX_W-1:0]            wr_idx;
  logic                         wr_zero;
  logic                         wr_en;

  wrf_cwp_ctrl #(.NUM_WIN(NUM_WIN)) i_cwp (
    .clk_i, .rst_ni, .call_i, .ret_i, .inv_mask_i,
    .cwp_o(cwp), .ovf_o, .unf_o
  );

  wrf_map #(.NUM_WIN(NUM_WIN)) i_wmap (
    .cwp_i(cwp), .arch_i(waddr_i), .phys_o(wr_idx), .zero_o(wr_zero)
  );

  assign wr_en      = we_i && !wr_zero;
  assign rd_arch[0] = raddr_a_i;
  assign rd_arch[1] = raddr_b_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    wrf_map #(.NUM_WIN(NUM_WIN)) i_rmap (
      .cwp_i(cwp), .arch_i(rd_arch[p]), .phys_o(rd_idx[p]), .zero_o(rd_zero[p])
    );
    wrf_read_port #(.DATA_W(DATA_W), .PIDX_W(PIDX_W)) i_rport (
      .zero_i(rd_zero[p]), .rd_idx_i(rd_idx[p]), .mem_data_i(mem_data[p]),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wdata_i),
      .rd_data_o(rd_data[p])
    );
  end

  wrf_storage #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .NRD(NRD)) i_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wdata_i),
    .rd_idx_i(rd_idx), .rd_data_o(mem_data)
  );

  assign rdata_a_o = rd_data[0];
  assign rdata_b_o = rd_data[1];
  assign cwp_o     = cwp;

  p_zero_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0))
    else $error("register 0 not zero");
  p_bypass_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && waddr_i == raddr_a_i) |-> (rdata_a_o == wdata_i))
    else $error("port A bypass");
  p_bypass_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && waddr_i == raddr_b_i) |-> (rdata_b_o == wdata_i))
    else $error("port B bypass");
  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && !call_i && !ret_i) |=> (we_i || raddr_a_i != $past(waddr_i) ||
      rdata_a_o == $past(wdata_i)))
    else $error("write did not land in issuing window");
endmodule

// File: tb/test_win_regfile.sv
module test_win_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call = 1'b0, ret = 1'b0, we = 1'b0;
  logic [NW-1:0] mask = '0;
  logic [4:0]    waddr = '0, raddr_a = '0, raddr_b = '0;
  logic [31:0]   wdata = '0, rdata_a, rdata_b;
  logic [2:0]    cwp;
  logic          ovf, unf;
  int            n_chk = 0, n_fail = 0;
  int            ec = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  win_regfile #(.NUM_WIN(NW), .DATA_W(32)) i_win_regfile (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret), .inv_mask_i(mask),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .raddr_a_i(raddr_a), .raddr_b_i(raddr_b),
    .rdata_a_o(rdata_a), .rdata_b_o(rdata_b), .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic logic [31:0] loc_v(int w, int a); return 32'hA000_0000 | (w << 8) | a; endfunction
  function automatic logic [31:0] in_v(int w, int a);  return 32'hB000_0000 | (w << 8) | a; endfunction
  function automatic logic [31:0] glb_v(int a);        return 32'hC000_0000 | a;            endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    raddr_a = 5'(a);
    raddr_b = 5'(a);
    #1;
    chk(rdata_a == exp, tag, rdata_a, exp);
    chk(rdata_b == exp, tag, rdata_b, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 5'(a); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic cmd(input bit c, input bit r);
    @(negedge clk);
    call = c; ret = r;
    @(posedge clk); #1;
    call = 1'b0; ret = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] xv;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    chk(cwp == 0, "R9 cwp", 32'(cwp), 0);
    chk(!ovf && !unf, "R9 flags", {30'b0, ovf, unf}, 0);
    for (int a = 0; a < 32; a++) rd(a, 32'h0, "R9 reg");

    // R1 register 0
    wr(0, 32'hDEAD_BEEF);
    rd(0, 32'h0, "R1 after write");
    @(negedge clk);
    we = 1'b1; waddr = 5'd0; wdata = 32'h1234_5678; raddr_a = 5'd0; raddr_b = 5'd0;
    #1;
    chk(rdata_a == 0 && rdata_b == 0, "R1 same-cycle", rdata_a, 0);
    @(posedge clk); #1; we = 1'b0;

    // globals, written in window 0
    for (int a = 1; a < 8; a++) wr(a, glb_v(a));

    // fill each window, stepping up with returns
    for (int s = 0; s < NW; s++) begin
      for (int a = 16; a < 32; a++) wr(a, (a < 24) ? loc_v(ec, a) : in_v(ec, a));
      cmd(1'b0, 1'b1);
      ec = (ec + 1) % NW;
      chk(cwp == 3'(ec), "R5 return step", 32'(cwp), 32'(ec));
    end

    // sweep all windows, stepping down with calls
    for (int s = 0; s < NW; s++) begin
      for (int a = 1; a < 8; a++)   rd(a, glb_v(a), "R2 global");
      for (int a = 16; a < 24; a++) rd(a, loc_v(ec, a), "R3 private");
      for (int a = 24; a < 32; a++) rd(a, in_v(ec, a), "R4 upper group");
      for (int a = 8; a < 16; a++)  rd(a, in_v((ec + NW - 1) % NW, a + 16), "R4 lower alias");
      cmd(1'b1, 1'b0);
      ec = (ec + NW - 1) % NW;
      chk(cwp == 3'(ec), "R5 call step", 32'(cwp), 32'(ec));
    end

    // R5 both / neither
    cmd(1'b1, 1'b1);
    chk(cwp == 3'(ec), "R5 both hold", 32'(cwp), 32'(ec));
    cmd(1'b0, 1'b0);
    chk(cwp == 3'(ec), "R5 idle hold", 32'(cwp), 32'(ec));

    // R6 overflow
    @(negedge clk); mask = NW'(1) << ((ec + NW - 1) % NW);
    cmd(1'b1, 1'b0);
    chk(cwp == 3'(ec), "R6 pointer held", 32'(cwp), 32'(ec));
    chk(ovf == 1'b1, "R6 ovf set", 32'(ovf), 1);
    chk(unf == 1'b0, "R6 unf low", 32'(unf), 0);
    idle();
    chk(ovf == 1'b0, "R6 ovf one cycle", 32'(ovf), 0);
    cmd(1'b0, 1'b1);
    ec = (ec + 1) % NW;
    chk(cwp == 3'(ec) && !unf, "R6 return allowed", 32'(cwp), 32'(ec));

    // R7 underflow
    @(negedge clk); mask = NW'(1) << ((ec + 1) % NW);
    cmd(1'b0, 1'b1);
    chk(cwp == 3'(ec), "R7 pointer held", 32'(cwp), 32'(ec));
    chk(unf == 1'b1 && ovf == 1'b0, "R7 unf set", {30'b0, ovf, unf}, 1);
    idle();
    chk(unf == 1'b0, "R7 unf one cycle", 32'(unf), 0);
    cmd(1'b1, 1'b0);
    ec = (ec + NW - 1) % NW;
    chk(cwp == 3'(ec) && !ovf, "R7 call allowed", 32'(cwp), 32'(ec));
    @(negedge clk); mask = '0;
    cmd(1'b0, 1'b1);
    ec = (ec + 1) % NW;

    // R8 bypass
    xv = 32'h5A5A_0011;
    @(negedge clk);
    we = 1'b1; waddr = 5'd17; wdata = xv; raddr_a = 5'd17; raddr_b = 5'd24;
    #1;
    chk(rdata_a == xv, "R8 bypass hit", rdata_a, xv);
    chk(rdata_b == in_v(ec, 24), "R8 other unaffected", rdata_b, in_v(ec, 24));
    raddr_b = 5'd17;
    #1;
    chk(rdata_b == xv, "R8 bypass port B", rdata_b, xv);
    @(posedge clk); #1; we = 1'b0;
    rd(17, xv, "R8 stored");

    // R10 write issued with a call
    xv = 32'h0BAD_F00D;
    @(negedge clk);
    we = 1'b1; waddr = 5'd20; wdata = xv; call = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; call = 1'b0;
    rd(20, loc_v((ec + NW - 1) % NW, 20), "R10 callee untouched");
    cmd(1'b0, 1'b1);
    rd(20, xv, "R10 caller written");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule